// File: doc/BRIEF.md
# RGMII receive sampling retimer

This block moves the five RGMII receive lanes (the data-valid lane and the four data lanes) onto a fast, free-running timing clock and decides when, inside each half-cycle of the receive clock, every lane is sampled. The receive clock and the lanes are brought into the timing-clock domain through matched synchronizer chains. An edge detector on the synchronized receive clock restarts a small counter on every rising and every falling edge. In adjust mode a half-cycle's sample is taken when that counter reaches a programmed delay. Any lane can be marked as slow, and a slow lane is taken one tick later. In bypass mode each half-cycle's sample is simply the lane state seen at the edge.

Software sets static controls: enable, an automatic-setup bit, a delay, a per-lane skew mask and the interface mode. The block latches these at rising edges of the receive clock, so a half-cycle pair never mixes settings. Each completed receive-clock cycle is delivered as a pair of lane words, one for the rising half and one for the falling half, together with a one-tick valid strobe. These pairs feed the MAC's double-data-rate receive path.

Top module: `rgmii_rx_retimer`

## Requirements
- R1: When adjust mode is not active, each half-cycle's word is the lane state present in the tick at which its edge is detected, and the word is complete in that tick.
- R2: The counter restarts on both rising and falling edges of the receive clock, and it reads 0 in the first tick after the edge is detected. Receive clock and lanes each reach the edge detector and sampler SYNC_STAGES ticks after they are applied.
- R3: In adjust mode, a lane whose skew bit is 0 is sampled in the tick where the counter equals the active delay, which is delay+1 ticks after the edge tick.
- R4: The lane vector and the skew mask share bit positions: bit 0 is the data-valid lane, bit 1 is data bit 3, bit 2 is data bit 2, bit 3 is data bit 1 and bit 4 is data bit 0. A lane whose skew bit is 1 is sampled one tick after the counter match.
- R5: The counter saturates at its maximum value (31 with a 5-bit counter) and does not wrap. A lane not yet sampled when the next edge arrives is sampled in that edge tick.
- R6: With setup set, the programmed delay and skew mask are ignored. The active delay becomes SETUP_DELAY and no lane is skewed.
- R7: Adjust mode is active only when enable is 1 and mode_rgmii is 1. With mode_rgmii at 0 (RMII) every receive-delay setting has no effect, and the block behaves as in R1.
- R8: Enable, setup, delay, skew and mode are captured only in the tick where a rising receive-clock edge is detected. Changes at any other time take effect at the next rising edge.
- R9: After a falling half's word completes, pair_valid is high for exactly one tick, starting one tick later. pair_rise then carries the preceding rising half's word and pair_fall carries the falling half's word.
- R10: After reset the outputs are zero. No pair is emitted before a rising half has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tclk | input | 1 | Free-running timing-adjustment clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_clk | input | 1 | Receive clock, sampled as data |
| rx_lanes | input | LANES (5) | Receive lanes, ordered as in R4 |
| cfg_enable | input | 1 | Selects adjust mode (1) or bypass (0) |
| cfg_setup | input | 1 | Automatic alignment, overrides delay and skew |
| mode_rgmii | input | 1 | 1 = RGMII, 0 = RMII (settings ignored) |
| cfg_delay | input | CNT_W (5) | Counter value at which sampling occurs |
| cfg_skew | input | LANES (5) | Per-lane one-tick extra delay |
| pair_rise | output | LANES (5) | Rising-half word of the last receive cycle |
| pair_fall | output | LANES (5) | Falling-half word of the last receive cycle |
| pair_valid | output | 1 | One-tick strobe for a new pair |

## Verification
The bench builds the block with five lanes, a 5-bit counter and a two-stage synchronizer. It overrides SETUP_DELAY to 6, so the automatic delay differs from every delay the bench programs and the override in R6 shows up in the sampled values. With a 5-bit counter, a delay of 31 combined with 40-tick half-cycles exercises counter saturation. Shorter half-cycles exercise the clamp to the closing edge for both plain and skewed lanes. Unequal rising and falling half lengths, together with delay values changed only while the receive clock is low, show that the counter restarts on both edges and that settings are picked up only at rising edges.

// File: rtl/rrt_pkg.sv
`timescale 1ns/1ps
package rrt_pkg;
   // which half of the receive clock period is currently being sampled
   typedef enum logic {HALF_FALL = 1'b0, HALF_RISE = 1'b1} half_e;
   // fewest flops allowed on the receive-clock synchronizer
   localparam int unsigned SYNC_MIN = 2;
endpackage

// File: rtl/rrt_edge_sync.sv
`timescale 1ns/1ps
module rrt_edge_sync #(
   parameter int LANES       = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_clk,
   input  logic [LANES-1:0] lanes_raw,
   output logic [LANES-1:0] lanes_al,
   output logic             rise_p,
   output logic             fall_p
);
   logic [SYNC_STAGES-1:0] clk_pipe;
   logic [LANES-1:0]       lane_pipe [SYNC_STAGES];
   logic                   clk_last;

   // lanes travel through a chain of equal depth so they stay aligned with the clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_pipe <= '0;
         clk_last <= 1'b0;
         for (int i = 0; i < SYNC_STAGES; i++) lane_pipe[i] <= '0;
      end else begin
         clk_pipe     <= {clk_pipe[SYNC_STAGES-2:0], rx_clk};
         clk_last     <= clk_pipe[SYNC_STAGES-1];
         lane_pipe[0] <= lanes_raw;
         for (int i = 1; i < SYNC_STAGES; i++) lane_pipe[i] <= lane_pipe[i-1];
      end
   end

   assign rise_p   =  clk_pipe[SYNC_STAGES-1] & ~clk_last;
   assign fall_p   = ~clk_pipe[SYNC_STAGES-1] &  clk_last;
   assign lanes_al = lane_pipe[SYNC_STAGES-1];
endmodule

// File: rtl/rrt_cfg_latch.sv
`timescale 1ns/1ps
module rrt_cfg_latch #(
   parameter int LANES       = 5,
   parameter int CNT_W       = 5,
   parameter int SETUP_DELAY = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_p,
   input  logic             cfg_enable,
   input  logic             cfg_setup,
   input  logic             mode_rgmii,
   input  logic [CNT_W-1:0] cfg_delay,
   input  logic [LANES-1:0] cfg_skew,
   output logic             act_adj,
   output logic [CNT_W-1:0] act_dly,
   output logic [LANES-1:0] act_skew,
   output logic             nxt_adj
);
   localparam logic [CNT_W-1:0] AUTO_DLY = CNT_W'(SETUP_DELAY);

   logic             want_adj;
   logic [CNT_W-1:0] want_dly;
   logic [LANES-1:0] want_skew;

   // RMII forces bypass; setup overrides the programmed timing
   assign want_adj  = cfg_enable & mode_rgmii;
   assign want_dly  = cfg_setup ? AUTO_DLY : cfg_delay;
   assign want_skew = cfg_setup ? '0 : cfg_skew;
   assign nxt_adj   = rise_p ? want_adj : act_adj;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_adj  <= 1'b0;
         act_dly  <= '0;
         act_skew <= '0;
      end else if (rise_p) begin
         act_adj  <= want_adj;
         act_dly  <= want_dly;
         act_skew <= want_skew;
      end
   end
endmodule

// File: rtl/rrt_half_sampler.sv
`timescale 1ns/1ps
module rrt_half_sampler #(
   parameter int LANES = 5,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_p,
   input  logic             start_byp,
   input  logic [LANES-1:0] lanes_al,
   input  logic [CNT_W-1:0] act_dly,
   input  logic [LANES-1:0] act_skew,
   output logic             old_cpl,
   output logic [LANES-1:0] old_word,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             hit_q;
   logic             done_q;
   logic [LANES-1:0] got_q;
   logic [LANES-1:0] word_q;
   logic [LANES-1:0] take;
   logic             match;
   logic             early_done;
   logic             closing;

   assign match = ~done_q & (cnt_q == act_dly);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      // slow lanes follow the match by one tick
      assign take[g]     = ~done_q & ~got_q[g] & (act_skew[g] ? hit_q : match);
      assign old_word[g] = got_q[g] ? word_q[g] : lanes_al[g];
   end

   assign early_done = ~edge_p & ~done_q & (&(got_q | take));
   assign closing    =  edge_p & ~done_q;
   assign old_cpl    = closing | early_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hit_q  <= 1'b0;
         done_q <= 1'b1;
         got_q  <= '1;
         word_q <= '0;
      end else if (edge_p) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
         if (start_byp) begin
            got_q  <= '1;
            word_q <= lanes_al;
            done_q <= 1'b1;
         end else begin
            got_q  <= '0;
            done_q <= 1'b0;
         end
      end else begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
         hit_q  <= match;
         got_q  <= got_q | take;
         word_q <= (word_q & ~take) | (lanes_al & take);
         done_q <= done_q | early_done;
      end
   end
endmodule

// File: rtl/rgmii_rx_retimer.sv
`timescale 1ns/1ps
module rgmii_rx_retimer #(
   parameter int LANES       = 5,
   parameter int CNT_W       = 5,
   parameter int SYNC_STAGES = 2,
   parameter int SETUP_DELAY = 4
) (
   input  logic             tclk,
   input  logic             rst_n,
   input  logic             rx_clk,
   input  logic [LANES-1:0] rx_lanes,
   input  logic             cfg_enable,
   input  logic             cfg_setup,
   input  logic             mode_rgmii,
   input  logic [CNT_W-1:0] cfg_delay,
   input  logic [LANES-1:0] cfg_skew,
   output logic [LANES-1:0] pair_rise,
   output logic [LANES-1:0] pair_fall,
   output logic             pair_valid
);
   import rrt_pkg::*;

   if (SYNC_STAGES < int'(SYNC_MIN)) begin : g_bad_sync
      $error("SYNC_STAGES below minimum");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (SETUP_DELAY < 0 || SETUP_DELAY >= (1 << CNT_W)) begin : g_bad_setup
      $error("SETUP_DELAY does not fit the counter");
   end

   logic [LANES-1:0] lanes_al;
   logic             rise_p;
   logic             fall_p;
   logic             edge_p;
   logic             act_adj;
   logic [CNT_W-1:0] act_dly;
   logic [LANES-1:0] act_skew;
   logic             nxt_adj;
   logic             old_cpl;
   logic [LANES-1:0] old_word;
   logic [CNT_W-1:0] cnt_q;
   logic             new_cpl;
   half_e            cur_half;
   logic             have_rise;
   logic [LANES-1:0] rise_hold;

   rrt_edge_sync #(.LANES(LANES), .SYNC_STAGES(SYNC_STAGES)) i_sync (
      .clk(tclk), .rst_n(rst_n), .rx_clk(rx_clk), .lanes_raw(rx_lanes),
      .lanes_al(lanes_al), .rise_p(rise_p), .fall_p(fall_p));

   assign edge_p = rise_p | fall_p;

   rrt_cfg_latch #(.LANES(LANES), .CNT_W(CNT_W), .SETUP_DELAY(SETUP_DELAY)) i_cfg (
      .clk(tclk), .rst_n(rst_n), .rise_p(rise_p), .cfg_enable(cfg_enable),
      .cfg_setup(cfg_setup), .mode_rgmii(mode_rgmii), .cfg_delay(cfg_delay),
      .cfg_skew(cfg_skew), .act_adj(act_adj), .act_dly(act_dly),
      .act_skew(act_skew), .nxt_adj(nxt_adj));

   rrt_half_sampler #(.LANES(LANES), .CNT_W(CNT_W)) i_smp (
      .clk(tclk), .rst_n(rst_n), .edge_p(edge_p), .start_byp(~nxt_adj),
      .lanes_al(lanes_al), .act_dly(act_dly), .act_skew(act_skew),
      .old_cpl(old_cpl), .old_word(old_word), .cnt_q(cnt_q));

   // a bypass half is finished in the very tick its edge shows up
   assign new_cpl = edge_p & ~nxt_adj;

   always_ff @(posedge tclk or negedge rst_n) begin
      if (!rst_n) begin
         cur_half   <= HALF_FALL;
         have_rise  <= 1'b0;
         rise_hold  <= '0;
         pair_rise  <= '0;
         pair_fall  <= '0;
         pair_valid <= 1'b0;
      end else begin
         pair_valid <= 1'b0;
         if (edge_p) cur_half <= rise_p ? HALF_RISE : HALF_FALL;
         if (old_cpl) begin
            if (cur_half == HALF_RISE) begin
               rise_hold <= old_word;
               have_rise <= 1'b1;
            end else if (have_rise) begin
               pair_valid <= 1'b1;
               pair_rise  <= rise_hold;
               pair_fall  <= old_word;
            end
         end
         if (new_cpl) begin
            if (rise_p) begin
               rise_hold <= lanes_al;
               have_rise <= 1'b1;
            end else if (have_rise) begin
               pair_valid <= 1'b1;
               pair_rise  <= rise_hold;
               pair_fall  <= lanes_al;
            end
         end
      end
   end
endmodule

// File: rtl/rrt_checker.sv
`timescale 1ns/1ps
module rrt_checker #(
   parameter int LANES       = 5,
   parameter int CNT_W       = 5,
   parameter int SETUP_DELAY = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             edge_p,
   input logic             rise_p,
   input logic [CNT_W-1:0] cnt_q,
   input logic             act_adj,
   input logic [CNT_W-1:0] act_dly,
   input logic [LANES-1:0] act_skew,
   input logic             cfg_setup,
   input logic             mode_rgmii,
   input logic             pair_valid
);
   localparam logic [CNT_W-1:0] CNT_TOP  = '1;
   localparam logic [CNT_W-1:0] AUTO_DLY = CNT_W'(SETUP_DELAY);

   assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      edge_p |=> (cnt_q == '0));

   assert_cnt_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_p && cnt_q == CNT_TOP) |=> (cnt_q == CNT_TOP));

   assert_setup_override_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_p && cfg_setup) |=> (act_dly == AUTO_DLY && act_skew == '0));

   assert_rmii_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_p && !mode_rgmii) |=> !act_adj);

   assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rise_p |=> ($stable(act_adj) && $stable(act_dly) && $stable(act_skew)));

   assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pair_valid |=> !pair_valid);
endmodule

bind rgmii_rx_retimer rrt_checker #(
   .LANES(LANES), .CNT_W(CNT_W), .SETUP_DELAY(SETUP_DELAY)
) i_rrt_checker (
   .clk(tclk), .rst_n(rst_n), .edge_p(edge_p), .rise_p(rise_p), .cnt_q(cnt_q),
   .act_adj(act_adj), .act_dly(act_dly), .act_skew(act_skew),
   .cfg_setup(cfg_setup), .mode_rgmii(mode_rgmii), .pair_valid(pair_valid));

// File: tb/test_rgmii_rx_retimer.sv
`timescale 1ns/1ps
module test_rgmii_rx_retimer;
   localparam int SYNC = 2;
   localparam int SETD = 6;
   localparam int MAXN = 4000;

   logic       tclk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_clk = 1'b0;
   logic [4:0] rx_lanes = '0;
   logic       cfg_enable = 1'b0;
   logic       cfg_setup = 1'b0;
   logic       mode_rgmii = 1'b1;
   logic [4:0] cfg_delay = '0;
   logic [4:0] cfg_skew = '0;
   logic [4:0] pair_rise;
   logic [4:0] pair_fall;
   logic       pair_valid;

   rgmii_rx_retimer #(.LANES(5), .CNT_W(5), .SYNC_STAGES(SYNC), .SETUP_DELAY(SETD)) i_rgmii_rx_retimer (
      .tclk(tclk), .rst_n(rst_n), .rx_clk(rx_clk), .rx_lanes(rx_lanes),
      .cfg_enable(cfg_enable), .cfg_setup(cfg_setup), .mode_rgmii(mode_rgmii),
      .cfg_delay(cfg_delay), .cfg_skew(cfg_skew), .pair_rise(pair_rise),
      .pair_fall(pair_fall), .pair_valid(pair_valid));

   always #10 tclk = ~tclk;   // 50 MHz

   // stimulus per tick, and expected output per tick
   bit         d_clk [MAXN];
   logic [4:0] d_lane[MAXN];
   bit         d_en  [MAXN];
   bit         d_set [MAXN];
   bit         d_rg  [MAXN];
   logic [4:0] d_dly [MAXN];
   logic [4:0] d_skw [MAXN];
   string      d_tag [MAXN];
   bit         e_val [MAXN];
   logic [4:0] e_r   [MAXN];
   logic [4:0] e_f   [MAXN];
   int n = 0;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic add_tick(bit c, bit en, bit st, bit rg, logic [4:0] dl, logic [4:0] sk, string tag);
      d_clk[n] = c;   d_lane[n] = 5'($urandom);
      d_en[n]  = en;  d_set[n]  = st;  d_rg[n] = rg;
      d_dly[n] = dl;  d_skw[n]  = sk;  d_tag[n] = tag;
      n++;
   endtask

   // ncyc receive-clock periods; dl_low is presented only while rx_clk is low
   task automatic seg(string tag, int ncyc, int hr, int hf, bit en, bit st, bit rg,
                      logic [4:0] dl, logic [4:0] sk, logic [4:0] dl_low);
      for (int c = 0; c < ncyc; c++) begin
         for (int i = 0; i < hr; i++) add_tick(1'b1, en, st, rg, dl, sk, tag);
         for (int i = 0; i < hf; i++) add_tick(1'b0, en, st, rg, dl_low, sk, tag);
      end
   endtask

   // value seen at the sampling point in tick p (R2: SYNC ticks of latency)
   function automatic bit obs_clk(int p);
      return (p >= SYNC) ? d_clk[p-SYNC] : 1'b0;
   endfunction
   function automatic logic [4:0] obs_lane(int p);
      return (p >= SYNC) ? d_lane[p-SYNC] : 5'd0;
   endfunction

   // behavioural reference: half-cycles, their sampling ticks and pairing
   task automatic build_model();
      int ep[$];
      bit et[$];
      bit c_adj = 1'b0;
      int c_d = 0;
      logic [4:0] c_sk = '0;
      bit have_r = 1'b0;
      logic [4:0] rh = '0;
      for (int p = 0; p < n; p++) e_val[p] = 1'b0;
      for (int p = 1; p < n; p++)
         if (obs_clk(p) != obs_clk(p-1)) begin
            ep.push_back(p);
            et.push_back(obs_clk(p));
         end
      for (int j = 0; j < ep.size(); j++) begin
         int s = ep[j];
         int e = (j + 1 < ep.size()) ? ep[j+1] : n + 100;
         int tl[5];
         int cpl;
         logic [4:0] w;
         if (et[j]) begin   // R8: settings picked up at rising edges only
            c_adj = d_en[s] & d_rg[s];                     // R7
            c_d   = d_set[s] ? SETD : int'(d_dly[s]);      // R6
            c_sk  = d_set[s] ? 5'd0 : d_skw[s];
         end
         if (!c_adj) begin  // R1
            cpl = s;
            w = obs_lane(s);
         end else begin
            cpl = 0;
            for (int i = 0; i < 5; i++) begin
               tl[i] = s + 1 + c_d + (c_sk[i] ? 1 : 0);   // R3, R4
               if (tl[i] > e) tl[i] = e;                  // R5
               if (tl[i] > cpl) cpl = tl[i];
            end
            if (cpl < n)
               for (int i = 0; i < 5; i++) begin
                  logic [4:0] v;
                  v = obs_lane(tl[i]);
                  w[i] = v[i];
               end
         end
         if (cpl >= n) continue;
         if (et[j]) begin
            rh = w;
            have_r = 1'b1;
         end else if (have_r) begin   // R9, R10
            e_val[cpl] = 1'b1;
            e_r[cpl]   = rh;
            e_f[cpl]   = w;
         end
      end
   endtask

   task automatic compare(int c);
      checks++;
      if (pair_valid !== e_val[c] ||
          (e_val[c] && (pair_rise !== e_r[c] || pair_fall !== e_f[c]))) begin
         errors++;
         $display("FAIL %s (R9 pairing) tick %0d: valid/rise/fall actual %b/%h/%h expected %b/%h/%h",
                  d_tag[c], c, pair_valid, pair_rise, pair_fall, e_val[c], e_r[c], e_f[c]);
      end
   endtask

   initial begin
      seg("R1",  8,  6,  6, 1'b0, 1'b0, 1'b1, 5'd0,  5'b00000, 5'd0);
      seg("R3",  8,  9,  9, 1'b1, 1'b0, 1'b1, 5'd2,  5'b00000, 5'd2);
      seg("R2",  6,  5, 12, 1'b1, 1'b0, 1'b1, 5'd1,  5'b00000, 5'd1);
      seg("R4",  8,  9,  9, 1'b1, 1'b0, 1'b1, 5'd3,  5'b10110, 5'd3);
      seg("R4",  6,  8,  8, 1'b1, 1'b0, 1'b1, 5'd0,  5'b11111, 5'd0);
      seg("R5",  6, 10, 10, 1'b1, 1'b0, 1'b1, 5'd20, 5'b00000, 5'd20);
      seg("R5",  4, 12, 12, 1'b1, 1'b0, 1'b1, 5'd10, 5'b00001, 5'd10);
      seg("R5",  3, 40, 40, 1'b1, 1'b0, 1'b1, 5'd31, 5'b01000, 5'd31);
      seg("R6",  6, 10, 10, 1'b1, 1'b1, 1'b1, 5'd1,  5'b11111, 5'd1);
      seg("R7",  6,  8,  8, 1'b1, 1'b0, 1'b0, 5'd4,  5'b00110, 5'd4);
      seg("R8",  6,  9,  9, 1'b1, 1'b0, 1'b1, 5'd2,  5'b00000, 5'd7);
      seg("R8",  4, 10, 10, 1'b1, 1'b0, 1'b1, 5'd5,  5'b00010, 5'd0);
      for (int i = 0; i < 60; i++) add_tick(1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 5'd0, "R9");
      build_model();

      repeat (4) @(negedge tclk);
      // R10: reset state
      checks++;
      if (pair_valid !== 1'b0 || pair_rise !== 5'd0 || pair_fall !== 5'd0) begin
         errors++;
         $display("FAIL R10 reset: valid/rise/fall actual %b/%h/%h expected 0/00/00",
                  pair_valid, pair_rise, pair_fall);
      end
      for (int k = 0; k < n; k++) begin
         @(negedge tclk);
         if (k == 0) rst_n = 1'b1;
         else compare(k - 1);
         rx_clk     = d_clk[k];
         rx_lanes   = d_lane[k];
         cfg_enable = d_en[k];
         cfg_setup  = d_set[k];
         mode_rgmii = d_rg[k];
         cfg_delay  = d_dly[k];
         cfg_skew   = d_skw[k];
      end
      @(negedge tclk);
      compare(n - 1);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge tclk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog (R9): run did not complete, actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule